// File: doc/BRIEF.md
# Sixteen-bit address arithmetic unit

This unit performs the wide arithmetic that an eight-bit CPU core needs for its register-pair and stack-pointer operations. A three-bit mode input picks one of five operations. Three of them work on the register pair: add, add with carry, and subtract with borrow. The other two add a signed byte displacement to the stack pointer. The two displacement modes differ only in where the result should go: back into the stack pointer, or into the register pair. The core supplies both 16-bit operands, the displacement byte and its current flag byte. The unit returns the 16-bit result, a new flag byte and a destination select bit. The core's register file then writes the result back. The register file is not part of this block.

The arithmetic and the flag logic are purely combinational. A small output stage captures their result on each accepted request, so a result appears one clock after it is requested, and one request can be accepted every cycle. The output stage is a two-state machine. In `OS_EMPTY` no valid result is presented. In `OS_FULL` the registered result is valid. The transition `take` moves the stage to, or keeps it in, `OS_FULL` whenever a legal request is accepted. The transition `drain` moves it to `OS_EMPTY` when a cycle passes with no accepted request.

The flag byte uses a fixed layout:
- bit 7 is Z (zero)
- bit 6 is N (subtract)
- bit 5 is H (half carry)
- bit 4 is C (carry)

Bits 3..0 of the produced flag byte are always zero. The mode encoding is:
- 0 is register-pair add
- 1 is add with carry
- 2 is subtract with borrow
- 3 is displacement into the stack pointer
- 4 is displacement into the register pair

Codes 5 to 7 are illegal.

Top module: `wide_addr_alu`

## Requirements
- R1: After reset, out_valid, out_result, out_flags and out_dest_sp are all zero.
- R2: A request with in_valid high and a legal mode (0..4) gives out_valid high on the next clock, with the matching result. In a cycle with no accepted request, out_valid is low on the next clock and the output result, flags and destination keep their previous values.
- R3: Mode 0 (add) gives result = opa + opb modulo 2^16, with C = carry out of bit 15 and N = 0. Z is copied unchanged from in_flags bit 7.
- R4: Mode 1 (add with carry) gives result = opa + opb + in_flags bit 4, with C = carry out of bit 15, N = 0, and Z = 1 exactly when the 16-bit result is zero.
- R5: Mode 2 (subtract with borrow) gives result = opa - opb - in_flags bit 4, with C = bit 16 of the 17-bit difference (set on borrow), N = 1, and Z = 1 exactly when the 16-bit result is zero.
- R6: H is bit 4 of (opa[15:8] XOR x XOR result[15:8]). Here x is opb[15:8] in modes 0 to 2, and the raw displacement byte in modes 3 and 4.
- R7: Modes 3 and 4 give result = opa + the displacement sign-extended to 17 bits. C is bit 16 of that 17-bit sum, and Z and N are both 0, whatever the input flags are.
- R8: out_dest_sp is 1 only for a result produced in mode 3, and 0 for every other mode, including mode 4.
- R9: A request with in_valid high and mode 5, 6 or 7 is ignored: out_valid is low on the next clock and the held outputs do not change.
- R10: Bits 3..0 of out_flags are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Operation code (0..4 legal) |
| in_opa | input | 16 | Register pair or stack pointer value |
| in_opb | input | 16 | Second register-pair operand |
| in_disp | input | 8 | Signed displacement byte |
| in_flags | input | 8 | Current flag byte (Z7 N6 H5 C4) |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 16 | Registered 16-bit result |
| out_flags | output | 8 | Registered updated flag byte |
| out_dest_sp | output | 1 | 1: write to stack pointer, 0: write to register pair |

## Verification
Each mode is driven with operands chosen to separate the flag rules from one another.

- Carries out of bit 11 and out of bit 15 show that H comes from the high bytes and that C comes from bit 16.
- Sums that wrap to zero show that the register-pair add keeps the incoming Z, while the carry forms compute Z.
- Subtractions with and without borrow-in, including a subtraction that goes negative, test the borrow and N behaviour.
- Positive and negative displacements around zero show that the sign extension is to 17 bits. They also show that Z and N are forced low even when every input flag is set.

Back-to-back requests, idle cycles and illegal codes check the one-cycle latency and that the held outputs do not change.

// File: rtl/wa_pkg.sv
package wa_pkg;

    typedef enum logic [2:0] {
        WM_ADD    = 3'd0,
        WM_ADC    = 3'd1,
        WM_SBC    = 3'd2,
        WM_SPD_SP = 3'd3,
        WM_SPD_HL = 3'd4
    } wa_mode_e;

    localparam int FLAG_W = 8;
    localparam int FZ     = 7;
    localparam int FN     = 6;
    localparam int FH     = 5;
    localparam int FC     = 4;

    function automatic logic mode_legal(input logic [2:0] m);
        return (m <= 3'd4);
    endfunction

    function automatic logic mode_is_disp(input logic [2:0] m);
        return (m == 3'd3) || (m == 3'd4);
    endfunction

endpackage

// File: rtl/wa_sum_path.sv
module wa_sum_path
    import wa_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int DISP_W = 8
) (
    input  logic [2:0]       mode,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [DISP_W-1:0] disp,
    input  logic             cin,
    output logic [WIDTH:0]   sum,
    output logic [WIDTH-1:0] hx
);
    localparam int EXT_W = WIDTH + 1 - DISP_W;
    localparam int PAD_W = WIDTH - DISP_W;

    logic [WIDTH:0] disp_ext;
    logic [WIDTH:0] a_ext;
    logic [WIDTH:0] b_ext;
    logic [WIDTH:0] c_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign a_ext    = {1'b0, opa};
    assign b_ext    = {1'b0, opb};
    assign c_ext    = {{WIDTH{1'b0}}, cin};

    always_comb begin
        case (mode)
            WM_ADD:    sum = a_ext + b_ext;
            WM_ADC:    sum = a_ext + b_ext + c_ext;
            WM_SBC:    sum = a_ext - b_ext - c_ext;
            WM_SPD_SP,
            WM_SPD_HL: sum = a_ext + disp_ext;
            default:   sum = '0;
        endcase
    end

    // Operand seen by the half-carry rule: the displacement takes the high byte slot.
    assign hx = mode_is_disp(mode) ? {disp, {PAD_W{1'b0}}} : opb;

endmodule

// File: rtl/wa_flag_path.sv
module wa_flag_path
    import wa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [2:0]        mode,
    input  logic              z_in,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  hx,
    input  logic [WIDTH:0]    sum,
    output logic [FLAG_W-1:0] flags
);
    localparam int HBIT = WIDTH - 4;

    logic [WIDTH-1:0] res;
    logic             zero_res;
    logic             h_bit;
    logic             c_bit;
    logic             z_bit;
    logic             n_bit;

    assign res      = sum[WIDTH-1:0];
    assign zero_res = (res == '0);
    assign h_bit    = opa[HBIT] ^ hx[HBIT] ^ res[HBIT];
    assign c_bit    = sum[WIDTH];

    always_comb begin
        case (mode)
            WM_ADD: begin
                z_bit = z_in;
                n_bit = 1'b0;
            end
            WM_ADC: begin
                z_bit = zero_res;
                n_bit = 1'b0;
            end
            WM_SBC: begin
                z_bit = zero_res;
                n_bit = 1'b1;
            end
            default: begin
                z_bit = 1'b0;
                n_bit = 1'b0;
            end
        endcase
    end

    always_comb begin
        flags     = '0;
        flags[FZ] = z_bit;
        flags[FN] = n_bit;
        flags[FH] = h_bit;
        flags[FC] = c_bit;
    end

endmodule

// File: rtl/wa_out_stage.sv
module wa_out_stage
    import wa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  d_result,
    input  logic [FLAG_W-1:0] d_flags,
    input  logic              d_dest_sp,
    output logic              out_valid,
    output logic [WIDTH-1:0]  out_result,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_dest_sp
);
    typedef enum logic {OS_EMPTY, OS_FULL} os_state_e;

    os_state_e state_q;
    os_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: state_d = load ? OS_FULL : OS_EMPTY;   // take
            OS_FULL:  state_d = load ? OS_FULL : OS_EMPTY;   // take / drain
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_flags   <= '0;
            out_dest_sp <= 1'b0;
        end else if (load) begin
            out_result  <= d_result;
            out_flags   <= d_flags;
            out_dest_sp <= d_dest_sp;
        end
    end

    assign out_valid = (state_q == OS_FULL);

    AST_LOAD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);                                            // R2
    AST_IDLE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !out_valid);                                          // R2
    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(out_result) && $stable(out_flags)));         // R9

endmodule

// File: rtl/wide_addr_alu.sv
module wide_addr_alu
    import wa_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_mode,
    input  logic [WIDTH-1:0]  in_opa,
    input  logic [WIDTH-1:0]  in_opb,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [FLAG_W-1:0] in_flags,
    output logic              out_valid,
    output logic [WIDTH-1:0]  out_result,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_dest_sp
);
    logic [WIDTH:0]      sum;
    logic [WIDTH-1:0]    hx;
    logic [FLAG_W-1:0]   new_flags;
    logic                accept;
    logic                dest_sp;
    logic                unused_flag_bits;

    assign accept           = in_valid && mode_legal(in_mode);
    assign dest_sp          = (in_mode == WM_SPD_SP);
    assign unused_flag_bits = ^{in_flags[FN], in_flags[FH], in_flags[3:0]};

    wa_sum_path #(.WIDTH(WIDTH), .DISP_W(DISP_W)) u_sum (
        .mode (in_mode),
        .opa  (in_opa),
        .opb  (in_opb),
        .disp (in_disp),
        .cin  (in_flags[FC]),
        .sum  (sum),
        .hx   (hx)
    );

    wa_flag_path #(.WIDTH(WIDTH)) u_flags (
        .mode  (in_mode),
        .z_in  (in_flags[FZ]),
        .opa   (in_opa),
        .hx    (hx),
        .sum   (sum),
        .flags (new_flags)
    );

    wa_out_stage #(.WIDTH(WIDTH)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .d_result    (sum[WIDTH-1:0]),
        .d_flags     (new_flags),
        .d_dest_sp   (dest_sp),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_flags   (out_flags),
        .out_dest_sp (out_dest_sp)
    );

    AST_ADD_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(in_mode) == WM_ADD) |-> out_flags[FZ] == $past(in_flags[FZ]));  // R3
    AST_SBC_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(in_mode) == WM_SBC) |-> out_flags[FN]);                          // R5
    AST_DISP_CLEARS_ZN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_is_disp($past(in_mode)) |-> !out_flags[FZ] && !out_flags[FN]);    // R7
    AST_DEST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_dest_sp == ($past(in_mode) == WM_SPD_SP));                         // R8
    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mode_legal(in_mode) |=> !out_valid && $stable(out_result));             // R9
    AST_LOW_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[3:0] == 4'h0);                                                             // R10

endmodule

// File: tb/tb_wide_addr_alu.sv
`timescale 1ns/1ps
module tb_wide_addr_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_mode = '0;
    logic [15:0] in_opa = '0;
    logic [15:0] in_opb = '0;
    logic [7:0]  in_disp = '0;
    logic [7:0]  in_flags = '0;
    logic        out_valid;
    logic [15:0] out_result;
    logic [7:0]  out_flags;
    logic        out_dest_sp;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wide_addr_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_opa(in_opa), .in_opb(in_opb), .in_disp(in_disp), .in_flags(in_flags),
        .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags),
        .out_dest_sp(out_dest_sp)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected {dest, flags, result} computed from the requirement text.
    function automatic logic [24:0] model(input int m, input int a, input int b,
                                          input int d, input int f);
        int r; int x; int ds; int cin; int z; int n;
        logic [16:0] r17; logic h; logic [7:0] fl;
        cin = (f >> 4) & 1;
        ds  = (d >= 128) ? d - 256 : d;
        x   = (b >> 8) & 255;
        z = 0; n = 0;
        case (m)
            0: begin r = a + b;       z = (f >> 7) & 1; end
            1: begin r = a + b + cin; z = ((r & 16'hFFFF) == 0); end
            2: begin r = a - b - cin; z = ((r & 16'hFFFF) == 0); n = 1; end
            default: begin r = a + ds; x = d; end
        endcase
        r17 = r[16:0];
        h   = (((a >> 8) ^ x ^ int'(r17[15:8])) >> 4) & 1;
        fl  = {z[0], n[0], h, r17[16], 4'h0};
        return {(m == 3), fl, r17[15:0]};
    endfunction

    task automatic op(input string req, input int m, input int a, input int b,
                      input int d, input int f);
        logic [24:0] e;
        e = model(m, a, b, d, f);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m[2:0]; in_opa = a[15:0]; in_opb = b[15:0];
        in_disp = d[7:0]; in_flags = f[7:0];
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(req, "valid",  int'(out_valid),   1);                 // R2
        chk(req, "result", int'(out_result),  int'(e[15:0]));
        chk(req, "flags",  int'(out_flags),   int'(e[23:16]));    // R6 R10
        chk(req, "dest",   int'(out_dest_sp), int'(e[24]));       // R8
    endtask

    task automatic t_reset();
        chk("R1", "valid",  int'(out_valid), 0);
        chk("R1", "result", int'(out_result), 0);
        chk("R1", "flags",  int'(out_flags), 0);
        chk("R1", "dest",   int'(out_dest_sp), 0);
    endtask

    task automatic t_add();
        op("R3", 0, 16'h0FFF, 16'h0001, 0, 8'h80);   // H from bit 11, Z kept
        op("R3", 0, 16'hFFFF, 16'h0001, 0, 8'h00);   // wraps to 0, Z stays 0
        op("R6", 0, 16'h1234, 16'h4321, 0, 8'h10);   // carry-in ignored
    endtask

    task automatic t_adc();
        op("R4", 1, 16'h1234, 16'h0001, 0, 8'h10);
        op("R4", 1, 16'hFFFF, 16'h0000, 0, 8'h10);   // zero with carry
        op("R4", 1, 16'h8000, 16'h8000, 0, 8'h80);
    endtask

    task automatic t_sbc();
        op("R5", 2, 16'h1000, 16'h0001, 0, 8'h00);   // borrow across bit 12
        op("R5", 2, 16'h0000, 16'h0000, 0, 8'h10);   // negative result
        op("R5", 2, 16'h0005, 16'h0004, 0, 8'h10);   // zero
    endtask

    task automatic t_disp();
        op("R7", 3, 16'hFFF8, 0, 8'h08, 8'hF0);
        op("R7", 3, 16'h0005, 0, 8'hFF, 8'hF0);      // negative, no carry
        op("R7", 4, 16'h0000, 0, 8'hFF, 8'hC0);      // wraps below zero
        op("R8", 4, 16'h0FF0, 0, 8'h10, 8'h00);
        op("R6", 3, 16'h7F00, 0, 8'h80, 8'h00);
    endtask

    task automatic t_hold();
        logic [15:0] r; logic [7:0] fl;
        op("R2", 1, 16'h0100, 16'h0200, 0, 8'h00);
        r = out_result; fl = out_flags;
        @(negedge clk); in_valid = 1'b0; in_mode = 3'd2; in_opa = 16'hAAAA;
        @(posedge clk); #1;
        chk("R2", "idle valid", int'(out_valid), 0);
        chk("R2", "idle hold",  int'(out_result), int'(r));
        for (int m = 5; m < 8; m++) begin
            @(negedge clk); in_valid = 1'b1; in_mode = m[2:0]; in_opa = 16'h5555;
            in_opb = 16'h3333; in_flags = 8'hF0;
            @(posedge clk); #1;
            in_valid = 1'b0;
            chk("R9", "illegal valid",  int'(out_valid), 0);
            chk("R9", "illegal result", int'(out_result), int'(r));
            chk("R9", "illegal flags",  int'(out_flags), int'(fl));
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_add();
        t_adc();
        t_sbc();
        t_disp();
        t_hold();
        op("R2", 2, 16'h0001, 16'h0002, 0, 8'h00);   // back-to-back tail
        op("R8", 3, 16'h0010, 0, 8'h01, 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule